// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a three-and-a-half digit dual-slope analog-to-digital converter. It divides the incoming oscillator clock by four to make a count clock. It then steps the analog front end through three phases: auto-zero, signal integrate and reference de-integrate. It drives one switch-control line per phase, and for de-integration it picks the reference sign that matches the input polarity. The analog switches, the integrator and the comparator sit outside the block. The comparator reaches it as a single asynchronous digital input.

Each conversion occupies a frame of 4000 counts. Integration always takes 1000 counts. De-integration stops as soon as the synchronized comparator output reverses, or when 2000 counts have passed. Auto-zero fills the rest of the frame, so the conversion rate does not depend on the input. The de-integrate time is counted in cascaded decimal stages. When auto-zero begins, that count is captured together with the polarity and an overrange flag. A hold input freezes the captured result.

Top module: `dsc_sequencer`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the auto-zero switch is on, every other switch and status output is off, and the reading, sign and overrange outputs are all zero.
- R2: The phase logic advances once every 4 clocks. The first auto-zero after reset lasts 1000 counts, so integration starts 4000 clocks after reset is released.
- R3: The integrate switch and the integrate status flag stay on for exactly 1000 counts (4000 clocks) in every frame.
- R4: The comparator passes through two flops. Its level at the last integrate count sets the polarity: high means a negative input, which selects the negative-input de-integrate switch and later gives a sign output of 1. Low selects the positive-input switch and gives a sign of 0.
- R5: De-integration ends on the first count where the synchronized comparator differs from the captured polarity. The reading is the number of counts completed before that count, from 0 to 1999. It is in BCD with the ones digit at bits [3:0], tens at [7:4], hundreds at [11:8] and thousands at [15:12].
- R6: If 2000 de-integrate counts pass without a reversal, de-integration stops. The latched reading is 1999 with the overrange flag set. A reversal seen on the 2000th count has priority and clears the flag.
- R7: Every frame, measured from one start of integration to the next, is exactly 4000 counts (16000 clocks). Auto-zero covers everything after de-integration.
- R8: The reading, sign and overrange outputs change only on the clock edge that begins auto-zero.
- R9: If hold is high on the clock edge that ends de-integration, the reading, sign and overrange outputs keep their previous values.
- R10: Exactly one of the four switch outputs is on in any cycle. The integrate status flag follows the integrate phase, and the de-integrate status flag is on during de-integration of either sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_i | input | 1 | Comparator output, asynchronous |
| hold_i | input | 1 | Freeze the result latch |
| sw_az | output | 1 | Auto-zero switch control |
| sw_int | output | 1 | Signal-integrate switch control |
| sw_de_pos | output | 1 | De-integrate switch for a positive input |
| sw_de_neg | output | 1 | De-integrate switch for a negative input |
| int_busy | output | 1 | Integrate phase status |
| deint_busy | output | 1 | De-integrate phase status |
| rd_digits | output | 16 | Latched BCD reading |
| rd_neg | output | 1 | Latched sign, 1 for a negative input |
| rd_over | output | 1 | Latched overrange flag |

## Verification
Two functions can fall on the same count clock. The first pair is the comparator reversal and the 2000-count limit: the bench flips the comparator so that the reversal arrives on exactly the 2000th de-integrate count. It expects a reading of 1999 with overrange clear, while a second frame with no reversal must set the flag. The second pair is hold and the result capture: hold is held high across the edge that ends de-integration. The outputs must keep the previous frame's result while the phase still moves on to auto-zero. A behavioural model in the bench follows every count and compares all outputs each clock.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_DE  = 2'd2
  } phase_t;
endpackage

// File: rtl/dsc_tick_div.sv
module dsc_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || cnt_q == LAST) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/dsc_sync2.sv
module dsc_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/dsc_bcd_count.sv
module dsc_bcd_count #(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                inc,
  output logic [4*DIGITS-1:0] value
);
  logic [3:0]        digit_q [DIGITS];
  logic [DIGITS-1:0] carry;

  assign carry[0] = inc;

  for (genvar i = 0; i < DIGITS; i++) begin : g_stage
    if (i < DIGITS - 1) begin : g_chain
      assign carry[i+1] = carry[i] && (digit_q[i] == 4'd9);
    end

    always_ff @(posedge clk) begin
      if (rst || clr)      digit_q[i] <= 4'd0;
      else if (carry[i])   digit_q[i] <= (digit_q[i] == 4'd9) ? 4'd0 : digit_q[i] + 4'd1;
    end

    assign value[4*i +: 4] = digit_q[i];
  end
endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer #(
  parameter int DIV          = 4,
  parameter int INT_COUNTS   = 1000,
  parameter int DEINT_MAX    = 2000,
  parameter int FRAME_COUNTS = 4000,
  parameter int DIGITS       = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmp_i,
  input  logic                hold_i,
  output logic                sw_az,
  output logic                sw_int,
  output logic                sw_de_pos,
  output logic                sw_de_neg,
  output logic                int_busy,
  output logic                deint_busy,
  output logic [4*DIGITS-1:0] rd_digits,
  output logic                rd_neg,
  output logic                rd_over
);
  import dsc_pkg::*;

  localparam int FCW = $clog2(FRAME_COUNTS);
  localparam int BW  = 4 * DIGITS;
  localparam logic [FCW-1:0] FC_LAST    = FCW'(FRAME_COUNTS - 1);
  localparam logic [FCW-1:0] FC_INT_END = FCW'(INT_COUNTS - 1);
  localparam logic [FCW-1:0] FC_RESET   = FCW'(INT_COUNTS + DEINT_MAX);

  function automatic logic [BW-1:0] to_bcd(input int v);
    int rem;
    rem = v;
    for (int i = 0; i < DIGITS; i++) begin
      to_bcd[4*i +: 4] = 4'(rem % 10);
      rem = rem / 10;
    end
  endfunction

  localparam logic [BW-1:0] LIMIT_BCD = to_bcd(DEINT_MAX - 1);

  logic           tick;
  logic           cmp_s;
  phase_t         phase_q;
  logic [FCW-1:0] fc_q;
  logic           pol_q;
  logic [BW-1:0]  count_bcd;
  logic           crossed, at_limit, cnt_clr, cnt_inc;

  dsc_tick_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  dsc_sync2 u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_i),
    .q   (cmp_s)
  );

  assign crossed  = (cmp_s != pol_q);
  assign at_limit = (count_bcd == LIMIT_BCD);
  assign cnt_clr  = tick && (phase_q == PH_AZ) && (fc_q == FC_LAST);
  assign cnt_inc  = tick && (phase_q == PH_DE) && !crossed && !at_limit;

  dsc_bcd_count #(.DIGITS(DIGITS)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .value (count_bcd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_AZ;
      fc_q      <= FC_RESET;
      pol_q     <= 1'b0;
      rd_digits <= '0;
      rd_neg    <= 1'b0;
      rd_over   <= 1'b0;
    end else if (tick) begin
      unique case (phase_q)
        PH_AZ: begin
          if (fc_q == FC_LAST) begin
            phase_q <= PH_INT;
            fc_q    <= '0;
          end else begin
            fc_q <= fc_q + 1'b1;
          end
        end
        PH_INT: begin
          fc_q <= fc_q + 1'b1;
          if (fc_q == FC_INT_END) begin
            phase_q <= PH_DE;
            pol_q   <= cmp_s;
          end
        end
        PH_DE: begin
          fc_q <= fc_q + 1'b1;
          if (crossed || at_limit) begin
            phase_q <= PH_AZ;
            if (!hold_i) begin
              rd_digits <= count_bcd;
              rd_neg    <= pol_q;
              rd_over   <= !crossed;
            end
          end
        end
        default: phase_q <= PH_AZ;
      endcase
    end
  end

  assign sw_az      = (phase_q == PH_AZ);
  assign sw_int     = (phase_q == PH_INT);
  assign sw_de_pos  = (phase_q == PH_DE) && !pol_q;
  assign sw_de_neg  = (phase_q == PH_DE) &&  pol_q;
  assign int_busy   = (phase_q == PH_INT);
  assign deint_busy = (phase_q == PH_DE);
endmodule

// File: rtl/dsc_sequencer_chk.sv
module dsc_sequencer_chk #(
  parameter int DIV          = 4,
  parameter int INT_COUNTS   = 1000,
  parameter int DEINT_MAX    = 2000,
  parameter int FRAME_COUNTS = 4000,
  parameter int DIGITS       = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                cmp_i,
  input logic                hold_i,
  input logic                sw_az,
  input logic                sw_int,
  input logic                sw_de_pos,
  input logic                sw_de_neg,
  input logic                int_busy,
  input logic                deint_busy,
  input logic [4*DIGITS-1:0] rd_digits,
  input logic                rd_neg,
  input logic                rd_over
);
  localparam int INT_CLKS = INT_COUNTS * DIV;
  localparam int DE_CLKS  = DEINT_MAX * DIV;

  int int_cyc, de_cyc;

  always_ff @(posedge clk) begin
    if (rst || !sw_int) int_cyc <= 0;
    else                int_cyc <= int_cyc + 1;
    if (rst || !deint_busy) de_cyc <= 0;
    else                    de_cyc <= de_cyc + 1;
  end

  // R10: one switch at a time
  a_r10_one_switch: assert property (@(posedge clk) disable iff (rst)
    $onehot({sw_az, sw_int, sw_de_pos, sw_de_neg}));

  // R3: integrate window length measured by a counter
  a_r3_int_len: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_int) |-> int_cyc == INT_CLKS);

  // R6: de-integration never exceeds its window
  a_r6_de_bound: assert property (@(posedge clk) disable iff (rst)
    deint_busy |-> de_cyc < DE_CLKS);

  // R6: thousands digit never above one
  a_r6_top_digit: assert property (@(posedge clk) disable iff (rst)
    rd_digits[4*DIGITS-1 -: 4] <= 4'd1);

  // R4: de-integration is always entered from integration
  a_r4_de_after_int: assert property (@(posedge clk) disable iff (rst)
    $rose(deint_busy) |-> $past(int_busy));

  // R8: result moves only when auto-zero begins
  a_r8_latch_edge: assert property (@(posedge clk) disable iff (rst)
    !$stable({rd_digits, rd_neg, rd_over}) |-> $rose(sw_az));

  // R9: hold freezes the result
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hold_i)) |-> $stable({rd_digits, rd_neg, rd_over}));

  // R7: integration is entered from auto-zero only
  a_r7_int_after_az: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_int) |-> $past(sw_az));
endmodule

bind dsc_sequencer dsc_sequencer_chk #(
  .DIV(DIV), .INT_COUNTS(INT_COUNTS), .DEINT_MAX(DEINT_MAX),
  .FRAME_COUNTS(FRAME_COUNTS), .DIGITS(DIGITS)
) u_chk (.*);

// File: tb/tb_dsc_sequencer.sv
module tb_dsc_sequencer;
  localparam int DIVN = 4;
  localparam int INTN = 1000;
  localparam int DEN  = 2000;
  localparam int FRN  = 4000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_i = 1'b0;
  logic hold_i = 1'b0;
  logic sw_az, sw_int, sw_de_pos, sw_de_neg, int_busy, deint_busy;
  logic [15:0] rd_digits;
  logic rd_neg, rd_over;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  dsc_sequencer dut (
    .clk(clk), .rst(rst), .cmp_i(cmp_i), .hold_i(hold_i),
    .sw_az(sw_az), .sw_int(sw_int), .sw_de_pos(sw_de_pos), .sw_de_neg(sw_de_neg),
    .int_busy(int_busy), .deint_busy(deint_busy),
    .rd_digits(rd_digits), .rd_neg(rd_neg), .rd_over(rd_over)
  );

  function automatic logic [15:0] bcd16(input int v);
    return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int m_div, m_phase, m_fc, m_cnt, m_rd;
  bit m_s1, m_s2, m_pol, m_neg, m_over;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_div = 0; m_s1 = 0; m_s2 = 0; m_phase = 0; m_fc = INTN + DEN;
      m_pol = 0; m_cnt = 0; m_rd = 0; m_neg = 0; m_over = 0;
    end else begin
      if (m_div == DIVN - 1) begin
        case (m_phase)
          0: if (m_fc == FRN - 1) begin m_phase = 1; m_fc = 0; m_cnt = 0; end
             else m_fc++;
          1: begin
               if (m_fc == INTN - 1) begin m_phase = 2; m_pol = m_s2; end
               m_fc++;
             end
          default: begin
               m_fc++;
               if (m_s2 != m_pol || m_cnt == DEN - 1) begin
                 if (!hold_i) begin
                   m_rd = m_cnt; m_neg = m_pol; m_over = (m_s2 == m_pol);
                 end
                 m_phase = 0;
               end else m_cnt++;
             end
        endcase
      end
      m_div = (m_div + 1) % DIVN;
      m_s2 = m_s1;
      m_s1 = cmp_i;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst && !done) begin
      check(sw_az == (m_phase == 0), "R7", "sw_az", int'(sw_az), int'(m_phase == 0));
      check(sw_int == (m_phase == 1), "R3", "sw_int", int'(sw_int), int'(m_phase == 1));
      check(sw_de_pos == (m_phase == 2 && !m_pol), "R4", "sw_de_pos", int'(sw_de_pos), int'(m_phase == 2 && !m_pol));
      check(sw_de_neg == (m_phase == 2 && m_pol), "R4", "sw_de_neg", int'(sw_de_neg), int'(m_phase == 2 && m_pol));
      check(int_busy == (m_phase == 1), "R10", "int_busy", int'(int_busy), int'(m_phase == 1));
      check(deint_busy == (m_phase == 2), "R10", "deint_busy", int'(deint_busy), int'(m_phase == 2));
      check(rd_digits == bcd16(m_rd), "R5", "rd_digits", int'(rd_digits), int'(bcd16(m_rd)));
      check(rd_neg == m_neg, "R4", "rd_neg", int'(rd_neg), int'(m_neg));
      check(rd_over == m_over, "R6", "rd_over", int'(rd_over), int'(m_over));
    end
  end

  int last_int_start = -1;

  // one conversion: polarity neg, reversal after val counts (val < 0: never)
  task automatic convert(input bit neg, input int val, input bit hold);
    logic [15:0] prev_d;
    bit prev_n, prev_o;
    int len;
    prev_d = rd_digits; prev_n = rd_neg; prev_o = rd_over;
    while (!sw_int) @(negedge clk);
    if (last_int_start >= 0)
      check(cyc - last_int_start == FRN * DIVN, "R7", "frame clocks", cyc - last_int_start, FRN * DIVN);
    last_int_start = cyc;
    cmp_i = neg;
    hold_i = hold;
    len = 0;
    while (sw_int) begin @(negedge clk); len++; end
    check(len == INTN * DIVN, "R3", "integrate clocks", len, INTN * DIVN);
    check(neg ? sw_de_neg : sw_de_pos, "R4", "de switch sign", int'({sw_de_neg, sw_de_pos}), neg ? 2 : 1);
    if (val >= 0) begin
      repeat (DIVN * val) @(negedge clk);
      cmp_i = !neg;
    end
    while (!sw_az) @(negedge clk);
    hold_i = 1'b0;
    if (hold) begin
      check(rd_digits == prev_d && rd_neg == prev_n && rd_over == prev_o, "R9", "held result",
            int'({rd_over, rd_neg, rd_digits}), int'({prev_o, prev_n, prev_d}));
    end else if (val < 0) begin
      check(rd_over && rd_digits == bcd16(DEN - 1), "R6", "overrange result",
            int'({rd_over, rd_digits}), int'({1'b1, bcd16(DEN - 1)}));
    end else begin
      check(rd_digits == bcd16(val) && !rd_over, "R5", "reading", int'({rd_over, rd_digits}), int'(bcd16(val)));
      check(rd_neg == neg, "R4", "sign", int'(rd_neg), int'(neg));
    end
    // R8: result steady through this auto-zero
    prev_d = rd_digits;
    repeat (200) @(negedge clk);
    check(rd_digits == prev_d, "R8", "stable during auto-zero", int'(rd_digits), int'(prev_d));
  endtask

  initial begin
    int n;
    repeat (5) @(negedge clk);
    check(sw_az && !sw_int && !sw_de_pos && !sw_de_neg && !int_busy && !deint_busy,
          "R1", "switches in reset", int'({sw_az, sw_int, sw_de_pos, sw_de_neg, int_busy, deint_busy}), 32);
    check(rd_digits == 0 && !rd_neg && !rd_over, "R1", "result in reset", int'({rd_over, rd_neg, rd_digits}), 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!sw_int && n < 10000);
    check(n == INTN * DIVN, "R2", "clocks to first integrate", n, INTN * DIVN);
    convert(1'b0, 123, 1'b0);
    convert(1'b1, 456, 1'b0);
    convert(1'b0, 0, 1'b0);
    convert(1'b1, DEN - 1, 1'b0);   // reversal on the limit count
    convert(1'b0, -1, 1'b0);        // overrange
    convert(1'b1, 777, 1'b1);       // hold across the capture edge
    convert(1'b0, 1000, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule